// File: doc/BRIEF.md
# Security Code Verification Unit

This block keeps the small security store of a card-style memory: a few-bit attempt counter at address 0 and a set of reference code bytes at the addresses above it. It watches every command that the command decoder hands on and runs the unlock procedure. The procedure burns one free counter bit, matches each reference byte in ascending order, and then erases the counter. When the procedure succeeds, the block raises a sticky unlock flag that the memory sequencer uses to permit writes and erases elsewhere.

Commands that modify the store (security update, compare) are accepted into a pending slot. They take effect on the clock edge where the external processing-done pulse arrives, which stands in for the non-volatile programming time. Any other command counts as an event on the cycle it is presented, and its only effect is on the sequence. A separate combinational read port returns the store contents, with the code bytes masked while locked. The counter and code bytes are non-volatile: the reset input clears only the unlock flag and the sequence progress.

Top module: `secu_top`

## Requirements
- R1: Read port address 0 returns the counter in the low 3 bits with the upper 5 bits zero. While locked, addresses 1 to 3 return 00h. While unlocked, they return the stored code bytes.
- R2: While locked, an update (opcode 39h) at address 00h sets the counter to the bitwise AND of its old value and data bits 2..0. Updates at addresses 01h to 03h leave the code bytes unchanged.
- R3: The sequence unlocks the block and sets the counter to 111b. It is: an update 39h at 00h that clears exactly one set counter bit; compares (opcode 33h) at 01h, 02h and 03h, in that order, each with data equal to that code byte; then an update 39h at 00h with data FFh.
- R4: A deviation returns the sequence to its start, and a following erase leaves the block locked with the counter unchanged. Deviations include a command other than the expected one, a compare at the wrong address, or a compare out of order.
- R5: A compare whose data differs from the addressed code byte fails the attempt, and the following erase is refused.
- R6: When the counter is 000b while locked, no burn is possible, so even a correct compare sequence followed by an erase leaves the block locked.
- R7: Once unlocked, the flag stays high through any command until reset. While unlocked, an update at 00h writes data bits 2..0 to the counter directly, and an update at 01h to 03h rewrites that code byte.
- R8: Reset clears the unlock flag and the sequence progress, and leaves the counter and code bytes unchanged.
- R9: The busy output rises in the cycle after an update or compare is accepted. It falls on the edge where processing-done is high, and the command takes effect on that edge. Commands presented while busy is high are ignored.
- R10: While locked, an update of FFh at 00h outside the final step of the sequence leaves the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset (clears unlock flag and sequence only) |
| cmd_valid | input | 1 | One-cycle pulse: a decoded command is presented |
| cmd_op | input | 8 | Command opcode (39h security update, 33h compare, others are non-security) |
| cmd_addr | input | 8 | Command address byte |
| cmd_data | input | 8 | Command data byte |
| proc_done | input | 1 | Processing-done pulse that completes a pending update or compare |
| busy | output | 1 | A pending update or compare awaits processing-done |
| rd_addr | input | 2 | Read port address into the security store |
| rd_data | output | 8 | Read port data (code bytes masked while locked) |
| unlocked | output | 1 | Sticky write/erase grant for the memory sequencer |

## Verification
The assertions take for granted that cmd_valid is a single-cycle pulse and that the counter and code registers start from their parameter values at power-up. They also assume that processing-done arrives some cycles after an accepted update or compare, and that reset is held across at least one edge. The bench drives each command on a falling edge and drops cmd_valid on the next. It raises processing-done only after it has seen busy high. It presents one extra command during busy on purpose to show that it is ignored. Because reset never restores the counter, the scenarios are ordered so that the available attempts are spent deliberately. The last scenario then reaches the fully burned counter.

// File: rtl/secu_pkg.sv
package secu_pkg;
   localparam logic [7:0] OP_SEC_UPDATE  = 8'h39;
   localparam logic [7:0] OP_SEC_COMPARE = 8'h33;

   function automatic logic op_needs_proc(input logic [7:0] op);
      return (op == OP_SEC_UPDATE) || (op == OP_SEC_COMPARE);
   endfunction
endpackage

// File: rtl/secu_store.sv
module secu_store
   import secu_pkg::*;
#(
   parameter int DW        = 8,
   parameter int CMD_AW    = 8,
   parameter int EC_W      = 3,
   parameter int REF_BYTES = 3,
   parameter logic [EC_W-1:0]         INIT_EC  = '1,
   parameter logic [REF_BYTES*DW-1:0] INIT_REF = '0
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ev_fire,
   input  logic [7:0]              ev_op,
   input  logic [CMD_AW-1:0]       ev_addr,
   input  logic [DW-1:0]           ev_data,
   input  logic                    unlocked_i,
   input  logic                    erase_i,
   output logic [EC_W-1:0]         ec_o,
   output logic [REF_BYTES*DW-1:0] ref_o
);
   logic wr_en;
   logic full_wr;
   logic [EC_W-1:0] ec_q = INIT_EC;

   assign wr_en   = ev_fire && (ev_op == OP_SEC_UPDATE);
   assign full_wr = unlocked_i || erase_i;

   always_ff @(posedge clk) begin
      if (wr_en && (ev_addr == '0)) begin
         if (full_wr) ec_q <= ev_data[EC_W-1:0];
         else         ec_q <= ec_q & ev_data[EC_W-1:0];
      end
   end
   assign ec_o = ec_q;

   for (genvar gi = 0; gi < REF_BYTES; gi++) begin : g_ref
      logic [DW-1:0] byte_q = INIT_REF[gi*DW +: DW];
      always_ff @(posedge clk) begin
         if (wr_en && unlocked_i && (ev_addr == CMD_AW'(gi + 1)))
            byte_q <= ev_data;
      end
      assign ref_o[gi*DW +: DW] = byte_q;
   end

   // counter bits can only rise through a granted full write (R2)
   p_ec_no_rise_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !full_wr |=> ((ec_q & ~$past(ec_q)) == '0));
endmodule

// File: rtl/secu_seq.sv
module secu_seq
   import secu_pkg::*;
#(
   parameter int DW        = 8,
   parameter int CMD_AW    = 8,
   parameter int EC_W      = 3,
   parameter int REF_BYTES = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ev_fire,
   input  logic [7:0]              ev_op,
   input  logic [CMD_AW-1:0]       ev_addr,
   input  logic [DW-1:0]           ev_data,
   input  logic [EC_W-1:0]         ec_i,
   input  logic [REF_BYTES*DW-1:0] ref_i,
   output logic                    unlocked_o,
   output logic                    erase_o
);
   localparam int LAST = REF_BYTES + 1;
   localparam int SW   = $clog2(REF_BYTES + 2);

   if (SW > CMD_AW) begin : g_bad_sw
      $error("secu_seq: stage width exceeds address width");
   end

   logic [SW-1:0]        stage_q;
   logic                 unlocked_q;
   logic [REF_BYTES-1:0] hit;
   logic                 cmp_ok;
   logic                 burn_ok;
   logic                 is_upd0;

   for (genvar gi = 0; gi < REF_BYTES; gi++) begin : g_hit
      assign hit[gi] = (ev_addr == CMD_AW'(gi + 1)) && (ev_data == ref_i[gi*DW +: DW]);
   end

   assign is_upd0 = (ev_op == OP_SEC_UPDATE) && (ev_addr == '0);
   assign cmp_ok  = (ev_op == OP_SEC_COMPARE) && (|hit) &&
                    (ev_addr == {{(CMD_AW-SW){1'b0}}, stage_q});
   assign burn_ok = is_upd0 && ($countones(ec_i & ~ev_data[EC_W-1:0]) == 1);
   assign erase_o = ev_fire && !unlocked_q && (stage_q == SW'(LAST)) &&
                    is_upd0 && (ev_data == '1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q    <= '0;
         unlocked_q <= 1'b0;
      end else if (ev_fire && !unlocked_q) begin
         if (stage_q == '0)
            stage_q <= burn_ok ? SW'(1) : '0;
         else if (stage_q < SW'(LAST))
            stage_q <= cmp_ok ? stage_q + 1'b1 : '0;
         else
            stage_q <= '0;
         if (erase_o) unlocked_q <= 1'b1;
      end
   end
   assign unlocked_o = unlocked_q;

   p_unlock_after_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unlocked_q) |-> ($past(stage_q) == SW'(LAST)));
   p_unlock_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      unlocked_q |=> unlocked_q);
   p_stage_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q != '0) |=> ((stage_q == '0) || (stage_q == $past(stage_q)) ||
                           (stage_q == $past(stage_q) + 1'b1)));
   p_blocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!unlocked_q && (stage_q == '0) && (ec_i == '0)) |=> (stage_q == '0));
endmodule

// File: rtl/secu_rdmux.sv
module secu_rdmux #(
   parameter int DW        = 8,
   parameter int EC_W      = 3,
   parameter int REF_BYTES = 3,
   parameter int AW        = 2
) (
   input  logic [AW-1:0]           rd_addr,
   input  logic                    unlocked_i,
   input  logic [EC_W-1:0]         ec_i,
   input  logic [REF_BYTES*DW-1:0] ref_i,
   output logic [DW-1:0]           rd_data
);
   logic [DW-1:0] ref_sel;

   always_comb begin
      ref_sel = '0;
      for (int i = 0; i < REF_BYTES; i++)
         if (rd_addr == AW'(i + 1)) ref_sel = ref_i[i*DW +: DW];
   end

   always_comb begin
      if (rd_addr == '0)   rd_data = {{(DW-EC_W){1'b0}}, ec_i};
      else if (unlocked_i) rd_data = ref_sel;
      else                 rd_data = '0;
   end
endmodule

// File: rtl/secu_top.sv
module secu_top
   import secu_pkg::*;
#(
   parameter int DW        = 8,
   parameter int CMD_AW    = 8,
   parameter int EC_W      = 3,
   parameter int REF_BYTES = 3,
   parameter logic [EC_W-1:0]         INIT_EC  = '1,
   parameter logic [REF_BYTES*DW-1:0] INIT_REF = 24'hC35AA7,
   localparam int AW = $clog2(REF_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [7:0]        cmd_op,
   input  logic [CMD_AW-1:0] cmd_addr,
   input  logic [DW-1:0]     cmd_data,
   input  logic              proc_done,
   output logic              busy,
   input  logic [AW-1:0]     rd_addr,
   output logic [DW-1:0]     rd_data,
   output logic              unlocked
);
   if (EC_W >= DW) begin : g_bad_ec
      $error("secu_top: counter must be narrower than a data byte");
   end
   if (REF_BYTES < 1 || REF_BYTES + 1 > 2**CMD_AW) begin : g_bad_ref
      $error("secu_top: code byte count out of range");
   end

   logic              busy_q;
   logic [7:0]        p_op;
   logic [CMD_AW-1:0] p_addr;
   logic [DW-1:0]     p_data;
   logic              accept;
   logic              ev_fire;
   logic [7:0]        ev_op;
   logic [CMD_AW-1:0] ev_addr;
   logic [DW-1:0]     ev_data;
   logic              erase_ok;
   logic [EC_W-1:0]   ec;
   logic [REF_BYTES*DW-1:0] refs;

   assign accept  = cmd_valid && !busy_q;
   assign ev_fire = (busy_q && proc_done) || (accept && !op_needs_proc(cmd_op));
   assign ev_op   = busy_q ? p_op   : cmd_op;
   assign ev_addr = busy_q ? p_addr : cmd_addr;
   assign ev_data = busy_q ? p_data : cmd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         p_op   <= '0;
         p_addr <= '0;
         p_data <= '0;
      end else if (busy_q) begin
         if (proc_done) busy_q <= 1'b0;
      end else if (accept && op_needs_proc(cmd_op)) begin
         busy_q <= 1'b1;
         p_op   <= cmd_op;
         p_addr <= cmd_addr;
         p_data <= cmd_data;
      end
   end
   assign busy = busy_q;

   secu_seq #(.DW(DW), .CMD_AW(CMD_AW), .EC_W(EC_W), .REF_BYTES(REF_BYTES)) u_seq (
      .clk(clk), .rst_n(rst_n), .ev_fire(ev_fire), .ev_op(ev_op), .ev_addr(ev_addr),
      .ev_data(ev_data), .ec_i(ec), .ref_i(refs), .unlocked_o(unlocked), .erase_o(erase_ok));

   secu_store #(.DW(DW), .CMD_AW(CMD_AW), .EC_W(EC_W), .REF_BYTES(REF_BYTES),
                .INIT_EC(INIT_EC), .INIT_REF(INIT_REF)) u_store (
      .clk(clk), .rst_n(rst_n), .ev_fire(ev_fire), .ev_op(ev_op), .ev_addr(ev_addr),
      .ev_data(ev_data), .unlocked_i(unlocked), .erase_i(erase_ok), .ec_o(ec), .ref_o(refs));

   secu_rdmux #(.DW(DW), .EC_W(EC_W), .REF_BYTES(REF_BYTES), .AW(AW)) u_rd (
      .rd_addr(rd_addr), .unlocked_i(unlocked), .ec_i(ec), .ref_i(refs), .rd_data(rd_data));

   p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !proc_done) |=> busy_q);
   p_busy_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(proc_done));
   p_ref_stable_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> $stable(refs));
endmodule

// File: tb/secu_top_tb.sv
`timescale 1ns/1ps
module secu_top_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [7:0] cmd_op = '0;
   logic [7:0] cmd_addr = '0;
   logic [7:0] cmd_data = '0;
   logic       proc_done = 1'b0;
   logic       busy;
   logic [1:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       unlocked;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   secu_top #(.INIT_EC(3'b111), .INIT_REF(24'hC35AA7)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .proc_done(proc_done),
      .busy(busy), .rd_addr(rd_addr), .rd_data(rd_data), .unlocked(unlocked));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic send(input logic [7:0] op, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d;
      @(negedge clk);
      cmd_valid = 1'b0;
      if (op == 8'h39 || op == 8'h33) begin
         repeat (3) @(negedge clk);
         proc_done = 1'b1;
         @(negedge clk);
         proc_done = 1'b0;
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset_state();
      logic [7:0] d;
      check("R8 unlock after reset", unlocked, 0);
      check("R9 busy after reset", busy, 0);
      rd(2'd0, d); check("R1 counter read", d, 8'h07);
      rd(2'd1, d); check("R1 code1 masked", d, 8'h00);
      rd(2'd3, d); check("R1 code3 masked", d, 8'h00);
   endtask

   task automatic t_busy_ignore();
      logic [7:0] d;
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = 8'h39; cmd_addr = 8'h01; cmd_data = 8'h00;
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R9 busy after accept", busy, 1);
      cmd_valid = 1'b1; cmd_op = 8'h39; cmd_addr = 8'h00; cmd_data = 8'h00;
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R9 busy holds", busy, 1);
      rd(2'd0, d); check("R9 no effect before done", d, 8'h07);
      proc_done = 1'b1;
      @(negedge clk);
      proc_done = 1'b0;
      check("R9 busy falls on done", busy, 0);
      rd(2'd0, d); check("R9 command during busy ignored", d, 8'h07);
   endtask

   task automatic t_locked_writes();
      logic [7:0] d;
      send(8'h39, 8'h02, 8'h00);
      send(8'h39, 8'h00, 8'hFF);
      rd(2'd0, d); check("R10 erase outside sequence", d, 8'h07);
      check("R10 still locked", unlocked, 0);
   endtask

   task automatic t_mismatch();
      logic [7:0] d;
      send(8'h39, 8'h00, 8'hFE);
      rd(2'd0, d); check("R2 burn ANDs counter", d, 8'h06);
      send(8'h33, 8'h01, 8'hA7);
      send(8'h33, 8'h02, 8'h00);
      send(8'h33, 8'h03, 8'hC3);
      send(8'h39, 8'h00, 8'hFF);
      rd(2'd0, d); check("R5 erase refused after mismatch", d, 8'h06);
      check("R5 locked after mismatch", unlocked, 0);
   endtask

   task automatic t_deviation();
      logic [7:0] d;
      send(8'h39, 8'h00, 8'hFD);
      rd(2'd0, d); check("R2 second burn", d, 8'h04);
      send(8'h33, 8'h02, 8'h5A);
      send(8'h33, 8'h01, 8'hA7);
      send(8'h33, 8'h02, 8'h5A);
      send(8'h33, 8'h03, 8'hC3);
      send(8'h39, 8'h00, 8'hFF);
      rd(2'd0, d); check("R4 erase refused after out-of-order", d, 8'h04);
      check("R4 locked after deviation", unlocked, 0);
   endtask

   task automatic t_reset_keeps();
      logic [7:0] d;
      do_reset();
      check("R8 unlock cleared", unlocked, 0);
      rd(2'd0, d); check("R8 counter kept", d, 8'h04);
   endtask

   task automatic t_unlock();
      logic [7:0] d;
      send(8'h39, 8'h00, 8'hFB);
      rd(2'd0, d); check("R3 last bit burned", d, 8'h00);
      send(8'h33, 8'h01, 8'hA7);
      send(8'h33, 8'h02, 8'h5A);
      send(8'h33, 8'h03, 8'hC3);
      check("R3 not yet unlocked", unlocked, 0);
      send(8'h39, 8'h00, 8'hFF);
      check("R3 unlocked", unlocked, 1);
      rd(2'd0, d); check("R3 counter erased", d, 8'h07);
   endtask

   task automatic t_unlocked_ops();
      logic [7:0] d;
      rd(2'd1, d); check("R1 code1 visible", d, 8'hA7);
      rd(2'd2, d); check("R2 locked code write refused", d, 8'h5A);
      send(8'h39, 8'h02, 8'h66);
      rd(2'd2, d); check("R7 code rewrite", d, 8'h66);
      send(8'h30, 8'h10, 8'h00);
      check("R7 sticky after other command", unlocked, 1);
      send(8'h39, 8'h00, 8'h00);
      rd(2'd0, d); check("R7 direct counter write", d, 8'h00);
      check("R7 sticky after counter write", unlocked, 1);
   endtask

   task automatic t_blocked();
      logic [7:0] d;
      do_reset();
      check("R8 relocked", unlocked, 0);
      rd(2'd2, d); check("R1 masked after relock", d, 8'h00);
      send(8'h39, 8'h00, 8'hF8);
      send(8'h33, 8'h01, 8'hA7);
      send(8'h33, 8'h02, 8'h66);
      send(8'h33, 8'h03, 8'hC3);
      send(8'h39, 8'h00, 8'hFF);
      check("R6 blocked stays locked", unlocked, 0);
      rd(2'd0, d); check("R6 counter stays zero", d, 8'h00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_busy_ignore();
      t_locked_writes();
      t_mismatch();
      t_deviation();
      t_reset_keeps();
      t_unlock();
      t_unlocked_ops();
      t_blocked();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule